// File: doc/BRIEF.md
# Serial Control Register Target for an Audio Effect Path

This block is a write-only two-wire serial bus target that holds the four control words of an audio effect path. The words are the effect mode, the space level, the centre level and the input level. A host writes them over SCL and SDA. The block samples both lines with its own system clock and finds START and STOP conditions. It accepts an address byte whose low address bit comes from a strap pin. It then takes a subaddress byte and stores the data bytes that follow into the register bank. It acknowledges each accepted byte by pulling SDA low through an open-drain enable.

The subaddress byte has two fields. Its top bit selects auto-increment. Its two low bits pick the first register. Without auto-increment, every data byte lands in that one register. With auto-increment, the register pointer advances after each byte. Once the pointer has passed the last register, further bytes are still acknowledged but are discarded.

Each committed write raises a one-cycle strobe with the register index. In that same cycle the output bus already shows the new value.

The controller is a single state machine with eight named states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_SUB`: shifting in the subaddress byte.
- `ST_SUB_ACK`: acknowledging the subaddress.
- `ST_DATA`: shifting in a data byte.
- `ST_DATA_ACK`: acknowledging a data byte, with the register write issued on entry.
- `ST_IGNORE`: the transfer was not for this target.

Its transitions are:
- Any state goes to `ST_ADDR` on START.
- Any state goes to `ST_IDLE` on STOP.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a match, or to `ST_IGNORE` otherwise. Either move happens at the SCL fall after the eighth bit.
- `ST_ADDR_ACK` goes to `ST_SUB` at the next SCL fall.
- `ST_SUB` goes to `ST_SUB_ACK` at the SCL fall after the eighth bit.
- `ST_SUB_ACK` goes to `ST_DATA` at the next SCL fall.
- `ST_DATA` goes to `ST_DATA_ACK` at the SCL fall after the eighth bit.
- `ST_DATA_ACK` goes back to `ST_DATA` at the next SCL fall.
- `ST_IGNORE` leaves only on START or STOP.

Top module: `audio_ctl_target`

## Requirements
- R1: After reset, the mode output is 0x00 (effect off), the space and centre outputs are 0x20 (their mute code, bit 5 set) and the input-level output is 0x40 (its mute code, bit 6 set). The pull enable and the strobe are low.
- R2: An address byte of 0x80 with the strap low, or 0x82 with the strap high, is acknowledged. The target pulls SDA low while SCL is high on the ninth clock.
- R3: An address byte whose upper seven bits do not match, or whose bit 0 is 1 (read), is not acknowledged. Every byte after it, up to the next START or STOP, is neither acknowledged nor written.
- R4: Subaddress bits 1:0 pick the register: 0 mode, 1 space, 2 centre, 3 input level. Bits 6:2 have no effect.
- R5: With subaddress bit 7 clear, every data byte until STOP is written to the selected register.
- R6: With subaddress bit 7 set, each data byte goes to the current register and the pointer then advances by one. Bytes that arrive after register 3 has been written are not stored.
- R7: Every data byte in an addressed transfer is acknowledged, including bytes that are discarded.
- R8: Each stored byte raises the write strobe for exactly one clock, with the register index on the index output. The output bus shows the new value in that same clock.
- R9: A repeated START at any point, including in the middle of a data byte, restarts address reception. A byte that was cut short is not written.
- R10: A STOP at any point returns the target to idle. Registers written earlier keep their values, and a partly received byte is dropped.
- R11: The SDA pull enable never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the pin |
| sda_in | input | 1 | Serial data line as seen on the pin |
| addr_strap | input | 1 | Low address bit strap |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| mode_q | output | 8 | Mode register (bit 0 effect on, bit 1 stereo) |
| space_q | output | 8 | Space level register |
| center_q | output | 8 | Centre level register |
| inlvl_q | output | 8 | Input level register |
| wr_stb | output | 1 | One-cycle pulse on each stored byte |
| wr_idx | output | 2 | Index of the register just written |

## Verification
The hardest case to reach from the pins is a bus condition that lands where the protocol does not expect one. One example is a START or STOP that cuts a data byte short after a few bits. Another is a long auto-increment burst that runs past the last register, where the target must keep acknowledging while it stops storing. The bench drives a bit-level bus master that can send any number of bits before a START or STOP. It sweeps every start register with bursts longer than the bank, and logs every strobe with the register value seen in that same clock.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } frame_state_t;

    localparam int BYTE_BITS = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_BITS + 1);

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

    // R9
    start_needs_high_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (scl_d && !sda_d));

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
    import audio_ctl_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_sel,
    output logic [BYTE_BITS-1:0] wr_data
);

    localparam int PTR_W = SEL_W + 1;

    frame_state_t          state;
    frame_state_t          state_nxt;
    logic [BIT_CNT_W-1:0]  bit_cnt;
    logic [BYTE_BITS-1:0]  shreg;
    logic [PTR_W-1:0]      ptr;
    logic                  inc_en;
    logic                  byte_full;
    logic                  rx_state;
    logic                  addr_ok;

    assign byte_full = (bit_cnt == BIT_CNT_W'(BYTE_BITS));
    assign rx_state  = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);
    assign addr_ok   = (shreg[BYTE_BITS-1 -: ADDR_W] == dev_addr) && !shreg[0];

    // next-state decision
    always_comb begin
        state_nxt = state;
        if (start_det) begin
            state_nxt = ST_ADDR;
        end else if (stop_det) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nxt = ST_IDLE;
                ST_ADDR:     if (byte_full && scl_fall)
                                 state_nxt = addr_ok ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_nxt = ST_SUB;
                ST_SUB:      if (byte_full && scl_fall) state_nxt = ST_SUB_ACK;
                ST_SUB_ACK:  if (scl_fall) state_nxt = ST_DATA;
                ST_DATA:     if (byte_full && scl_fall) state_nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) state_nxt = ST_DATA;
                ST_IGNORE:   state_nxt = ST_IGNORE;
                default:     state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // byte assembly and register pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            inc_en  <= 1'b0;
        end else begin
            if (start_det || (state_nxt != state)) begin
                bit_cnt <= '0;
            end else if (rx_state && scl_rise && !byte_full) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= {shreg[BYTE_BITS-2:0], sda_s};
            end
            if (state == ST_SUB && state_nxt == ST_SUB_ACK) begin
                inc_en <= shreg[BYTE_BITS-1];
                ptr    <= {1'b0, shreg[SEL_W-1:0]};
            end else if (state == ST_DATA && state_nxt == ST_DATA_ACK) begin
                if (inc_en && !ptr[PTR_W-1])
                    ptr <= ptr + 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            wr_sel   <= '0;
            wr_data  <= '0;
        end else begin
            sda_pull <= (state_nxt == ST_ADDR_ACK) || (state_nxt == ST_SUB_ACK) ||
                        (state_nxt == ST_DATA_ACK);
            wr_en    <= (state == ST_DATA) && (state_nxt == ST_DATA_ACK) && !ptr[PTR_W-1];
            wr_sel   <= ptr[SEL_W-1:0];
            wr_data  <= shreg;
        end
    end

    // R11
    pull_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && !scl_rise && !start_det && !stop_det) |=> $stable(sda_pull));

    // R9
    restart_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bit_cnt == '0));

    // R10
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE && !sda_pull));

    // R8
    write_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == ST_DATA_ACK && sda_pull));

    // R3
    ignore_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!sda_pull && !wr_en));

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank #(
    parameter int                          NUM_REGS = 4,
    parameter int                          DATA_W   = 8,
    parameter logic [NUM_REGS*DATA_W-1:0]  RST_VEC  = '0,
    localparam int                         IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_sel,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_q,
    output logic                       wr_stb,
    output logic [IDX_W-1:0]           wr_idx
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_q[g*DATA_W +: DATA_W] <= RST_VEC[g*DATA_W +: DATA_W];
            else if (wr_en && wr_sel == IDX_W'(g))
                regs_q[g*DATA_W +: DATA_W] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb <= 1'b0;
            wr_idx <= '0;
        end else begin
            wr_stb <= wr_en;
            wr_idx <= wr_sel;
        end
    end

    // R8
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R10
    hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

    // R8
    stb_shows_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_stb && regs_q[wr_idx*DATA_W +: DATA_W] == $past(wr_data)));

endmodule

// File: rtl/audio_ctl_target.sv
module audio_ctl_target #(
    parameter logic [6:0] DEV_ADDR_BASE = 7'h40,
    parameter logic [7:0] MODE_RST      = 8'h00,
    parameter logic [7:0] SPACE_RST     = 8'h20,
    parameter logic [7:0] CENTER_RST    = 8'h20,
    parameter logic [7:0] INLVL_RST     = 8'h40,
    parameter int         SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       addr_strap,
    output logic       sda_pull,
    output logic [7:0] mode_q,
    output logic [7:0] space_q,
    output logic [7:0] center_q,
    output logic [7:0] inlvl_q,
    output logic       wr_stb,
    output logic [1:0] wr_idx
);

    localparam int NUM_REGS = 4;
    localparam int DATA_W   = 8;
    localparam logic [NUM_REGS*DATA_W-1:0] RST_VEC =
        {INLVL_RST, CENTER_RST, SPACE_RST, MODE_RST};

    logic                       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic                       wr_en;
    logic [1:0]                 wr_sel;
    logic [DATA_W-1:0]          wr_data;
    logic [NUM_REGS*DATA_W-1:0] regs_q;
    logic [6:0]                 dev_addr;

    assign dev_addr = DEV_ADDR_BASE | {6'b0, addr_strap};

    bus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    frame_ctrl #(.ADDR_W(7), .SEL_W(2)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .sda_pull(sda_pull), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data)
    );

    ctl_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .RST_VEC(RST_VEC)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .regs_q(regs_q), .wr_stb(wr_stb), .wr_idx(wr_idx)
    );

    assign mode_q   = regs_q[0*DATA_W +: DATA_W];
    assign space_q  = regs_q[1*DATA_W +: DATA_W];
    assign center_q = regs_q[2*DATA_W +: DATA_W];
    assign inlvl_q  = regs_q[3*DATA_W +: DATA_W];

endmodule

// File: tb/test_audio_ctl_target.sv
module test_audio_ctl_target;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       addr_strap = 1'b0;
    logic       sda_pull;
    logic [7:0] mode_q, space_q, center_q, inlvl_q;
    logic       wr_stb;
    logic [1:0] wr_idx;
    logic       sda_line;

    assign sda_line = m_sda & ~sda_pull;

    audio_ctl_target i_audio_ctl_target (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .addr_strap(addr_strap), .sda_pull(sda_pull),
        .mode_q(mode_q), .space_q(space_q), .center_q(center_q), .inlvl_q(inlvl_q),
        .wr_stb(wr_stb), .wr_idx(wr_idx)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int stb_n = 0;
    logic [1:0] stb_idx [16];
    logic [7:0] stb_val [16];
    logic [7:0] model [4];
    logic [7:0] tx [8];
    logic       ack_log [10];
    int         edge_viol = 0;
    logic       prev_pull = 1'b0;

    function automatic logic [7:0] reg_out(input int i);
        case (i)
            0: return mode_q;
            1: return space_q;
            2: return center_q;
            default: return inlvl_q;
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (stb_n < 16) begin
                stb_idx[stb_n] = wr_idx;
                stb_val[stb_n] = reg_out(int'(wr_idx));
            end
            stb_n++;
        end
        if (rst_n && sda_pull != prev_pull && m_scl) edge_viol++;
        prev_pull = sda_pull;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bits(input logic [7:0] d, input int nb);
        for (int b = 7; b > 7 - nb; b--) begin
            m_sda = d[b]; wq(Q);
            m_scl = 1'b1; wq(2 * Q);
            m_scl = 1'b0; wq(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        send_bits(d, 8);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        ack = ~sda_line; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    // start, address byte, subaddress, n data bytes from tx, stop; acks into ack_log
    task automatic xfer(input logic [7:0] abyte, input logic [7:0] sub, input int n);
        logic a;
        stb_n = 0;
        bus_start();
        send_byte(abyte, a); ack_log[0] = a;
        send_byte(sub, a);   ack_log[1] = a;
        for (int k = 0; k < n; k++) begin
            send_byte(tx[k], a); ack_log[2 + k] = a;
        end
        bus_stop();
        wq(4);
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < 4; i++)
            check(reg_out(i) == model[i], tag, reg_out(i), model[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model[0] = 8'h00; model[1] = 8'h20; model[2] = 8'h20; model[3] = 8'h40;
        wq(5);
        rst_n = 1'b1;
        wq(5);
        // R1 reset state
        check_regs("R1 reset value");
        check(!sda_pull, "R1 pull idle", sda_pull, 0);
        check(!wr_stb, "R1 strobe idle", wr_stb, 0);

        // R2 / R3: address sweep over strap, address and direction
        for (int s = 0; s < 2; s++) begin
            logic [6:0] cand [4];
            addr_strap = s[0];
            cand[0] = 7'h40; cand[1] = 7'h41; cand[2] = 7'h42; cand[3] = 7'h20;
            for (int c = 0; c < 4; c++) begin
                for (int rw = 0; rw < 2; rw++) begin
                    logic exp_ack;
                    exp_ack = (cand[c] == (7'h40 | {6'b0, s[0]})) && (rw == 0);
                    tx[0] = 8'(8'h11 * (s * 8 + c * 2 + rw + 1));
                    xfer({cand[c], rw[0]}, 8'h03, 1);
                    if (exp_ack) model[3] = tx[0];
                    check(ack_log[0] == exp_ack, exp_ack ? "R2 address ack" : "R3 address nack",
                          ack_log[0], exp_ack);
                    check(ack_log[2] == exp_ack, "R3 data ack follows address", ack_log[2], exp_ack);
                    check(stb_n == (exp_ack ? 1 : 0), "R3 write count", stb_n, exp_ack);
                    check_regs("R3 register after address case");
                end
            end
        end
        addr_strap = 1'b0;

        // R4 / R5: fixed-register bursts with don't-care subaddress bits
        for (int r = 0; r < 4; r++) begin
            logic [7:0] dcs [3];
            dcs[0] = 8'h00; dcs[1] = 8'h7C; dcs[2] = 8'h28;
            for (int d = 0; d < 3; d++) begin
                for (int k = 0; k < 3; k++) tx[k] = 8'(r * 64 + d * 16 + k * 5 + 1);
                xfer(8'h80, dcs[d] | 8'(r), 3);
                model[r] = tx[2];
                check(stb_n == 3, "R5 three writes", stb_n, 3);
                for (int k = 0; k < 3; k++) begin
                    check(stb_idx[k] == 2'(r), "R4 selected index", stb_idx[k], r);
                    check(stb_val[k] == tx[k], "R8 value at strobe", stb_val[k], tx[k]);
                    check(ack_log[2 + k] == 1'b1, "R7 data ack", ack_log[2 + k], 1);
                end
                check_regs("R5 final registers");
            end
        end

        // R6 / R7: incremental bursts from every start register, longer than the bank
        for (int st = 0; st < 4; st++) begin
            for (int k = 0; k < 6; k++) tx[k] = 8'(8'hA0 + st * 16 + k);
            xfer(8'h80, 8'h80 | ((st % 2 == 1) ? 8'h60 : 8'h00) | 8'(st), 6);
            for (int k = 0; k < 6; k++) if (st + k <= 3) model[st + k] = tx[k];
            check(stb_n == 4 - st, "R6 write count", stb_n, 4 - st);
            for (int k = 0; k < 4 - st; k++) begin
                check(stb_idx[k] == 2'(st + k), "R6 index sequence", stb_idx[k], st + k);
                check(stb_val[k] == tx[k], "R8 value at strobe", stb_val[k], tx[k]);
            end
            for (int k = 0; k < 6; k++)
                check(ack_log[2 + k] == 1'b1, "R7 ack past last register", ack_log[2 + k], 1);
            check_regs("R6 final registers");
        end

        // R10: STOP in the middle of a data byte
        begin
            logic a;
            stb_n = 0;
            bus_start();
            send_byte(8'h80, a);
            send_byte(8'h02, a);
            send_byte(8'h5A, a); model[2] = 8'h5A;
            send_bits(8'hFF, 5);
            bus_stop();
            wq(4);
            check(stb_n == 1, "R10 partial byte dropped", stb_n, 1);
            check_regs("R10 registers after stop");
            tx[0] = 8'h3C;
            xfer(8'h80, 8'h01, 1); model[1] = 8'h3C;
            check(ack_log[0] == 1'b1, "R10 idle accepts next transfer", ack_log[0], 1);
            check_regs("R10 registers after next transfer");
        end

        // R9: repeated START mid-byte and right after the address acknowledge
        begin
            logic a;
            stb_n = 0;
            bus_start();
            send_byte(8'h80, a);
            send_byte(8'h01, a);
            send_byte(8'h77, a); model[1] = 8'h77;
            send_bits(8'h00, 3);
            bus_start();
            send_byte(8'h80, a);
            check(a == 1'b1, "R9 address after restart", a, 1);
            bus_start();
            send_byte(8'h80, a);
            send_byte(8'h02, a);
            send_byte(8'h99, a); model[2] = 8'h99;
            bus_stop();
            wq(4);
            check(stb_n == 2, "R9 write count across restarts", stb_n, 2);
            check_regs("R9 registers after restarts");
        end

        // R11
        check(edge_viol == 0, "R11 pull changed while SCL high", edge_viol, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule